// File: doc/BRIEF.md
# Receive Descriptor Status Word Builder

This block forms the 32-bit status word that a receive DMA engine writes back into a buffer descriptor each time it finishes with a receive buffer. The frame classifier supplies its results as inputs: address-filter hits, type-ID register hits, VLAN tag details, checksum verdicts, FCS health and the frame byte count. The DMA pulses `buf_wr` once per completed buffer and raises `buf_last` when that buffer closes the frame. One cycle later the block presents the word to be written.

A two-state machine tracks where the block is within a frame. `ST_HEAD` means the next buffer opens a frame, and `ST_BODY` means a frame is in progress. The transitions are HEAD→HEAD on a last buffer (a whole frame in one buffer), HEAD→BODY on a non-last buffer, BODY→BODY on a further non-last buffer, and BODY→HEAD on the last buffer. Reset enters `ST_HEAD`. Only the buffer that closes a frame carries the classification fields and the length. Earlier buffers carry at most the start-of-frame flag.

Three mode inputs change how fields are read or filled. Checksum offload reassigns bits 24:22. Ignore-FCS enables the bad-FCS flag. FCS-discard removes the FCS bytes from the reported length.

Top module: `rx_desc_status_builder`

## Requirements
- R1: While `rst_n` is low and after its release, `sts_valid` is 0 and `sts_word` is 0 until the first `buf_wr`.
- R2: Each cycle with `buf_wr` high produces `sts_valid` high on the next cycle. `sts_valid` is low in a cycle that follows a cycle without `buf_wr`, and `sts_word` then keeps its last value.
- R3: Bit 14 (start of frame) is set in the first buffer after reset or after a buffer with `buf_last`, and is clear otherwise. Bit 15 (end of frame) equals `buf_last`.
- R4: A word with bit 15 clear has every bit other than bit 14 at 0.
- R5: In a final word, bits 12:0 hold the low 13 bits of `byte_cnt`. When `fcs_discard_en` is 1, they hold `byte_cnt − 4` instead, with a floor of 0.
- R6: In a final word, bit 27 is the OR of `spec_addr_hit[3:0]`. Bits 26:25 give the index of the highest set hit bit (00 = hit bit 0 … 11 = hit bit 3), or 00 when there is none.
- R7: With `csum_offload_en` at 0, bit 24 in a final word is the OR of `type_id_hit[3:0]`, and bits 23:22 give the index of the highest set bit, using the same encoding as R6.
- R8: With `csum_offload_en` at 1, bit 24 equals `snap_ok`, and bits 23:22 equal `csum_verdict` (00 not checked, 01 IP header good only, 10 IP and TCP good, 11 IP and UDP good). The type hits have no effect.
- R9: In a final word, bit 21 equals `vlan_tagged`. Bit 20 is `prio_tagged` AND `vlan_tagged`. Bits 19:17 (`vlan_pcp`) and bit 16 (`vlan_cfi`) are passed through only when `vlan_tagged` is 1, and are 0 otherwise.
- R10: In a final word, bits 31, 30, 29 and 28 equal `bcast_hit`, `mcast_hash_hit`, `ucast_hash_hit` and `io_addr_hit` respectively.
- R11: In a final word, bit 13 equals `fcs_bad` when `ignore_fcs_en` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_wr | input | 1 | One-cycle strobe: a receive buffer is complete |
| buf_last | input | 1 | Qualifies `buf_wr`: this buffer closes the frame |
| csum_offload_en | input | 1 | Checksum offload mode |
| ignore_fcs_en | input | 1 | Frames with bad FCS are kept and flagged |
| fcs_discard_en | input | 1 | The FCS is excluded from the reported length |
| bcast_hit | input | 1 | All-ones broadcast destination |
| mcast_hash_hit | input | 1 | Multicast hash filter hit |
| ucast_hash_hit | input | 1 | Unicast hash filter hit |
| io_addr_hit | input | 1 | I/O address filter hit |
| spec_addr_hit | input | 4 | Per-register specific-address hits |
| type_id_hit | input | 4 | Per-register type-ID hits |
| snap_ok | input | 1 | SNAP encoded with no VLAN tag or with CFI clear |
| csum_verdict | input | 2 | Checksum check result |
| vlan_tagged | input | 1 | VLAN tag 0x8100 present |
| prio_tagged | input | 1 | VLAN tag with a null VLAN ID |
| vlan_pcp | input | 3 | VLAN priority code |
| vlan_cfi | input | 1 | VLAN canonical format indicator |
| fcs_bad | input | 1 | FCS check failed |
| byte_cnt | input | 14 | Received byte count, FCS included |
| sts_valid | output | 1 | `sts_word` is new this cycle |
| sts_word | output | 32 | Descriptor status word |

## Verification
A state register left in `ST_BODY` when it should be in `ST_HEAD` shows up on the very next buffer: bit 14 is missing from the word that should open a frame. The reverse fault puts a spurious start flag on a continuation buffer. Both can be seen one cycle after the `buf_wr` that exposes them. A wrong priority order in either encoder, or a mode select on the wrong field group, only appears in a final word. The directed scenarios therefore use several hits at once and close frames under each mode, so that every such fault changes a sampled word on the cycle after the strobe.

// File: rtl/rxsw_pkg.sv
package rxsw_pkg;

    localparam int WORD_W      = 32;
    localparam int MATCH_IDX_W = 2;
    localparam int NUM_MATCH   = 1 << MATCH_IDX_W;
    localparam int LEN_W       = 13;

    // bit positions decoded by descriptor software
    localparam int B_BCAST   = 31;
    localparam int B_MCAST   = 30;
    localparam int B_UCAST   = 29;
    localparam int B_IOADDR  = 28;
    localparam int B_SPEC    = 27;
    localparam int B_SPEC_LO = 25;
    localparam int B_TYPE    = 24;
    localparam int B_TYPE_LO = 22;
    localparam int B_VLAN    = 21;
    localparam int B_PRIO    = 20;
    localparam int B_PCP_LO  = 17;
    localparam int B_CFI     = 16;
    localparam int B_EOF     = 15;
    localparam int B_SOF     = 14;
    localparam int B_FCSBAD  = 13;

    typedef enum logic {
        ST_HEAD = 1'b0,
        ST_BODY = 1'b1
    } frame_st_e;

endpackage

// File: rtl/rxsw_prio_enc.sv
module rxsw_prio_enc #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // highest-numbered request wins: later iterations override
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) idx = i[IDX_W-1:0];
        end
    end

    assign any = |req;

endmodule

// File: rtl/rxsw_len_calc.sv
module rxsw_len_calc #(
    parameter int CNT_W     = 14,
    parameter int LEN_W     = 13,
    parameter int FCS_BYTES = 4
) (
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic             strip_fcs,
    output logic [LEN_W-1:0] len
);
    localparam logic [CNT_W-1:0] FCS_C = CNT_W'(FCS_BYTES);

    logic [CNT_W-1:0] adj;

    always_comb begin
        if (!strip_fcs)           adj = byte_cnt;
        else if (byte_cnt < FCS_C) adj = '0;
        else                       adj = byte_cnt - FCS_C;
        len = adj[LEN_W-1:0];
    end

endmodule

// File: rtl/rxsw_field_mux.sv
module rxsw_field_mux
    import rxsw_pkg::*;
(
    input  logic                   sof,
    input  logic                   csum_offload_en,
    input  logic                   ignore_fcs_en,
    input  logic                   bcast_hit,
    input  logic                   mcast_hash_hit,
    input  logic                   ucast_hash_hit,
    input  logic                   io_addr_hit,
    input  logic                   spec_any,
    input  logic [MATCH_IDX_W-1:0] spec_idx,
    input  logic                   type_any,
    input  logic [MATCH_IDX_W-1:0] type_idx,
    input  logic                   snap_ok,
    input  logic [1:0]             csum_verdict,
    input  logic                   vlan_tagged,
    input  logic                   prio_tagged,
    input  logic [2:0]             vlan_pcp,
    input  logic                   vlan_cfi,
    input  logic                   fcs_bad,
    input  logic [LEN_W-1:0]       len,
    output logic [WORD_W-1:0]      word
);
    always_comb begin
        word                              = '0;
        word[B_BCAST]                     = bcast_hit;
        word[B_MCAST]                     = mcast_hash_hit;
        word[B_UCAST]                     = ucast_hash_hit;
        word[B_IOADDR]                    = io_addr_hit;
        word[B_SPEC]                      = spec_any;
        word[B_SPEC_LO +: MATCH_IDX_W]    = spec_idx;
        if (csum_offload_en) begin
            word[B_TYPE]                  = snap_ok;
            word[B_TYPE_LO +: 2]          = csum_verdict;
        end else begin
            word[B_TYPE]                  = type_any;
            word[B_TYPE_LO +: MATCH_IDX_W] = type_idx;
        end
        word[B_VLAN]                      = vlan_tagged;
        word[B_PRIO]                      = vlan_tagged & prio_tagged;
        word[B_PCP_LO +: 3]               = vlan_tagged ? vlan_pcp : 3'b000;
        word[B_CFI]                       = vlan_tagged & vlan_cfi;
        word[B_EOF]                       = 1'b1;
        word[B_SOF]                       = sof;
        word[B_FCSBAD]                    = ignore_fcs_en & fcs_bad;
        word[LEN_W-1:0]                   = len;
    end

endmodule

// File: rtl/rx_desc_status_builder.sv
module rx_desc_status_builder
    import rxsw_pkg::*;
#(
    parameter int CNT_W     = 14,
    parameter int FCS_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 buf_wr,
    input  logic                 buf_last,
    input  logic                 csum_offload_en,
    input  logic                 ignore_fcs_en,
    input  logic                 fcs_discard_en,
    input  logic                 bcast_hit,
    input  logic                 mcast_hash_hit,
    input  logic                 ucast_hash_hit,
    input  logic                 io_addr_hit,
    input  logic [3:0]           spec_addr_hit,
    input  logic [3:0]           type_id_hit,
    input  logic                 snap_ok,
    input  logic [1:0]           csum_verdict,
    input  logic                 vlan_tagged,
    input  logic                 prio_tagged,
    input  logic [2:0]           vlan_pcp,
    input  logic                 vlan_cfi,
    input  logic                 fcs_bad,
    input  logic [CNT_W-1:0]     byte_cnt,
    output logic                 sts_valid,
    output logic [WORD_W-1:0]    sts_word
);
    localparam logic [WORD_W-1:0] SOF_ONLY = WORD_W'(1) << B_SOF;
    localparam logic [MATCH_IDX_W-1:0] TOP_IDX = MATCH_IDX_W'(NUM_MATCH - 1);

    frame_st_e st_q, st_d;

    logic                   spec_any, type_any;
    logic [MATCH_IDX_W-1:0] spec_idx, type_idx;
    logic [LEN_W-1:0]       len;
    logic [WORD_W-1:0]      final_word;
    logic                   at_head;

    assign at_head = (st_q == ST_HEAD);

    rxsw_prio_enc #(.N(NUM_MATCH), .IDX_W(MATCH_IDX_W)) u_spec_enc (
        .req (spec_addr_hit),
        .any (spec_any),
        .idx (spec_idx)
    );

    rxsw_prio_enc #(.N(NUM_MATCH), .IDX_W(MATCH_IDX_W)) u_type_enc (
        .req (type_id_hit),
        .any (type_any),
        .idx (type_idx)
    );

    rxsw_len_calc #(.CNT_W(CNT_W), .LEN_W(LEN_W), .FCS_BYTES(FCS_BYTES)) u_len (
        .byte_cnt  (byte_cnt),
        .strip_fcs (fcs_discard_en),
        .len       (len)
    );

    rxsw_field_mux u_mux (
        .sof             (at_head),
        .csum_offload_en (csum_offload_en),
        .ignore_fcs_en   (ignore_fcs_en),
        .bcast_hit       (bcast_hit),
        .mcast_hash_hit  (mcast_hash_hit),
        .ucast_hash_hit  (ucast_hash_hit),
        .io_addr_hit     (io_addr_hit),
        .spec_any        (spec_any),
        .spec_idx        (spec_idx),
        .type_any        (type_any),
        .type_idx        (type_idx),
        .snap_ok         (snap_ok),
        .csum_verdict    (csum_verdict),
        .vlan_tagged     (vlan_tagged),
        .prio_tagged     (prio_tagged),
        .vlan_pcp        (vlan_pcp),
        .vlan_cfi        (vlan_cfi),
        .fcs_bad         (fcs_bad),
        .len             (len),
        .word            (final_word)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HEAD: if (buf_wr && !buf_last) st_d = ST_BODY;
            ST_BODY: if (buf_wr &&  buf_last) st_d = ST_HEAD;
            default: st_d = ST_HEAD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HEAD;
        else        st_q <= st_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_valid <= 1'b0;
            sts_word  <= '0;
        end else begin
            sts_valid <= buf_wr;
            if (buf_wr) begin
                if (buf_last)     sts_word <= final_word;
                else if (at_head) sts_word <= SOF_ONLY;
                else              sts_word <= '0;
            end
        end
    end

    AST_VALID_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |=> sts_valid); // R2

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_wr |=> !sts_valid); // R2

    AST_SOF_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && at_head) |=> sts_word[B_SOF]); // R3

    AST_NO_SOF_IN_BODY: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && !at_head) |=> !sts_word[B_SOF]); // R3

    AST_NONFINAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_valid && !sts_word[B_EOF]) |-> ((sts_word & ~SOF_ONLY) == '0)); // R4

    AST_SPEC_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && buf_last && spec_addr_hit[NUM_MATCH-1]) |=>
        (sts_word[B_SPEC] && sts_word[B_SPEC_LO +: MATCH_IDX_W] == TOP_IDX)); // R6

    AST_VLAN_QUALIFIES: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_valid && !sts_word[B_VLAN]) |-> (sts_word[B_PRIO:B_CFI] == '0)); // R9

    AST_FCS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && !ignore_fcs_en) |=> !sts_word[B_FCSBAD]); // R11

endmodule

// File: tb/rx_desc_status_builder_tb.sv
module rx_desc_status_builder_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        buf_wr = 1'b0, buf_last = 1'b0;
    logic        csum_offload_en = 1'b0, ignore_fcs_en = 1'b0, fcs_discard_en = 1'b0;
    logic        bcast_hit = 1'b0, mcast_hash_hit = 1'b0, ucast_hash_hit = 1'b0, io_addr_hit = 1'b0;
    logic [3:0]  spec_addr_hit = '0, type_id_hit = '0;
    logic        snap_ok = 1'b0;
    logic [1:0]  csum_verdict = '0;
    logic        vlan_tagged = 1'b0, prio_tagged = 1'b0, vlan_cfi = 1'b0, fcs_bad = 1'b0;
    logic [2:0]  vlan_pcp = '0;
    logic [13:0] byte_cnt = '0;
    logic        sts_valid;
    logic [31:0] sts_word;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_desc_status_builder u_dut (
        .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_last(buf_last),
        .csum_offload_en(csum_offload_en), .ignore_fcs_en(ignore_fcs_en),
        .fcs_discard_en(fcs_discard_en), .bcast_hit(bcast_hit),
        .mcast_hash_hit(mcast_hash_hit), .ucast_hash_hit(ucast_hash_hit),
        .io_addr_hit(io_addr_hit), .spec_addr_hit(spec_addr_hit),
        .type_id_hit(type_id_hit), .snap_ok(snap_ok), .csum_verdict(csum_verdict),
        .vlan_tagged(vlan_tagged), .prio_tagged(prio_tagged), .vlan_pcp(vlan_pcp),
        .vlan_cfi(vlan_cfi), .fcs_bad(fcs_bad), .byte_cnt(byte_cnt),
        .sts_valid(sts_valid), .sts_word(sts_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] top_idx(input logic [3:0] h);
        logic [1:0] r = 2'b00;
        for (int i = 3; i >= 0; i--) if (h[i]) begin r = 2'(i); break; end
        return r;
    endfunction

    // expected word from the requirement text
    function automatic logic [31:0] model(input bit sof, input bit last);
        logic [31:0] w = '0;
        int l;
        w[14] = sof;
        if (!last) return w;
        w[15] = 1'b1;
        w[31] = bcast_hit; w[30] = mcast_hash_hit; w[29] = ucast_hash_hit; w[28] = io_addr_hit;
        w[27] = |spec_addr_hit; w[26:25] = top_idx(spec_addr_hit);
        if (csum_offload_en) begin w[24] = snap_ok; w[23:22] = csum_verdict; end
        else begin w[24] = |type_id_hit; w[23:22] = top_idx(type_id_hit); end
        w[21] = vlan_tagged;
        w[20] = vlan_tagged && prio_tagged;
        if (vlan_tagged) begin w[19:17] = vlan_pcp; w[16] = vlan_cfi; end
        w[13] = ignore_fcs_en && fcs_bad;
        l = int'(byte_cnt);
        if (fcs_discard_en) l = (l < 4) ? 0 : l - 4;
        w[12:0] = 13'(l);
        return w;
    endfunction

    task automatic push(input bit last, input bit sof, input string req);
        logic [31:0] e;
        @(negedge clk);
        buf_wr = 1'b1; buf_last = last;
        e = model(sof, last);
        @(posedge clk); #1;
        chk({req, " valid"}, {31'd0, sts_valid}, 32'd1);
        chk(req, sts_word, e);
        @(negedge clk);
        buf_wr = 1'b0; buf_last = 1'b0;
    endtask

    task automatic clear_inputs();
        {bcast_hit, mcast_hash_hit, ucast_hash_hit, io_addr_hit} = '0;
        spec_addr_hit = '0; type_id_hit = '0; snap_ok = 0; csum_verdict = '0;
        {vlan_tagged, prio_tagged, vlan_cfi, fcs_bad} = '0; vlan_pcp = '0;
        {csum_offload_en, ignore_fcs_en, fcs_discard_en} = '0;
        byte_cnt = 14'd64;
    endtask

    task automatic t_reset();
        #(CLK_PERIOD*2); @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 valid", {31'd0, sts_valid}, 32'd0);
        chk("R1 word", sts_word, 32'd0);
    endtask

    task automatic t_whole_frames();
        clear_inputs(); bcast_hit = 1; byte_cnt = 14'd60;
        push(1, 1, "R3 R10 whole bcast");
        clear_inputs(); mcast_hash_hit = 1; io_addr_hit = 1; byte_cnt = 14'd1518;
        push(1, 1, "R10 R5 mcast io");
        clear_inputs(); ucast_hash_hit = 1;
        push(1, 1, "R10 ucast");
        @(posedge clk); #1;
        chk("R2 idle no valid", {31'd0, sts_valid}, 32'd0);
        chk("R2 word held", sts_word, model(1, 1));
    endtask

    task automatic t_multi_buffer();
        clear_inputs(); bcast_hit = 1; spec_addr_hit = 4'b0011; vlan_tagged = 1; vlan_pcp = 3'd5;
        push(0, 1, "R3 R4 first of three");
        push(0, 0, "R3 R4 middle");
        byte_cnt = 14'd300;
        push(1, 0, "R3 R6 R9 last");
        clear_inputs();
        push(0, 1, "R3 next frame opens");
        push(1, 0, "R3 two-buffer close");
    endtask

    task automatic t_priority();
        clear_inputs(); spec_addr_hit = 4'b1111; type_id_hit = 4'b0101;
        push(1, 1, "R6 R7 all spec, type 0+2");
        clear_inputs(); spec_addr_hit = 4'b0001; type_id_hit = 4'b1000;
        push(1, 1, "R6 R7 spec0 type3");
        clear_inputs(); spec_addr_hit = 4'b0110; type_id_hit = 4'b0000;
        push(1, 1, "R6 R7 spec 1+2 no type");
    endtask

    task automatic t_offload();
        for (int v = 0; v < 4; v++) begin
            clear_inputs(); csum_offload_en = 1; type_id_hit = 4'b1111;
            csum_verdict = 2'(v); snap_ok = v[0];
            push(1, 1, "R8 offload verdict");
        end
    endtask

    task automatic t_vlan();
        clear_inputs(); vlan_tagged = 1; prio_tagged = 1; vlan_pcp = 3'd7; vlan_cfi = 1;
        push(1, 1, "R9 tagged prio");
        clear_inputs(); vlan_tagged = 0; prio_tagged = 1; vlan_pcp = 3'd6; vlan_cfi = 1;
        push(1, 1, "R9 untagged masks");
    endtask

    task automatic t_fcs_len();
        clear_inputs(); fcs_bad = 1;
        push(1, 1, "R11 bad fcs ignored mode off");
        clear_inputs(); fcs_bad = 1; ignore_fcs_en = 1;
        push(1, 1, "R11 bad fcs flagged");
        clear_inputs(); fcs_discard_en = 1; byte_cnt = 14'd64;
        push(1, 1, "R5 discard 64");
        clear_inputs(); fcs_discard_en = 1; byte_cnt = 14'd3;
        push(1, 1, "R5 discard floor");
        clear_inputs(); byte_cnt = 14'd9000;
        push(1, 1, "R5 truncate 13 bits");
        clear_inputs(); fcs_discard_en = 1; byte_cnt = 14'd8195;
        push(1, 1, "R5 discard then truncate");
    endtask

    initial begin
        clear_inputs();
        t_reset();
        t_whole_frames();
        t_multi_buffer();
        t_priority();
        t_offload();
        t_vlan();
        t_fcs_len();
        repeat (3) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule